// File: doc/BRIEF.md
# Switch MAC Address Table Engine

The block is a command-driven forwarding table for a small Ethernet switch. Software reaches it through a three-register port. It first loads a lookup key, which is a 12-bit VLAN ID plus a 48-bit MAC address split across two key registers. It then writes an access register that holds a command code, an entry type, a destination index and a valid flag. The engine carries out the command on a hashed table of buckets, each with several ways. While it works, the command field reads back the running code. When the command field reads zero, the operation is complete.

Learning, removal, lookup, in-place rewrite, whole-table clearing, a two-pass aging sweep and an ordered walk over all stored keys are all handled by one sequencer. The sequencer has a single write port into the entry store. Only entries of the NORMAL type age out. LOCKED and multicast entries stay until software removes them. Destination index 58 conventionally names the CPU port and is stored like any other index.

Top module: `mactab_engine`

## Requirements
- R1: After reset, all three registers read zero and the table holds no valid entry.
- R2: Register map:
  - Offset 0 holds MAC bytes 2..5 in bits 31:24, 23:16, 15:8 and 7:0.
  - Offset 1 holds the VID in bits 27:16, MAC byte 0 in bits 15:8 and MAC byte 1 in bits 7:0. Bits 31:28 read zero.
  - Offset 2 holds the command in 3:0, the entry type in 5:4, the destination in 12:6, the valid flag in 13 and the sticky full flag in 14.
  - The key is {VID, byte0..byte5}.
- R3: Command codes are 0 idle, 1 learn, 2 forget, 3 age, 4 next, 5 clear, 6 read, 7 write and 8 synchronous next. The command field shows the running code until completion and then reads 0. Codes 1, 2, 6, 7 and 9..15 finish one clock after the write. Codes 3, 4, 5 and 8 visit every entry once and take one clock per entry.
- R4: A learn with the valid flag at 1 installs the key with the given destination and type. If the key is already present, the existing entry is overwritten in place. In both cases the entry's age mark is cleared.
- R5: The bucket index is bit j = XOR of all key bits i with i mod BKT_W = j. A new key goes to the lowest free way of its bucket. If no way is free, it replaces the lowest way that holds an aged NORMAL entry. Otherwise the key is not stored and the full flag is set. The full flag stays set until a clear command.
- R6: A forget removes the matching key only when the stored type equals the type written with the command.
- R7: A learn with the valid flag at 0 removes the matching key whatever its type.
- R8: The clear command invalidates every entry and resets the full flag.
- R9: The age command sweeps the table. A NORMAL entry without an age mark receives one. A NORMAL entry that already has an age mark is removed. Entries of types 1, 2 and 3 are left unchanged.
- R10: A read returns valid 1 with the stored destination and type on a hit. On a miss it returns valid 0, destination 0 and type 0.
- R11: A write changes the destination and type of an existing key and reports valid 1. On a miss it changes nothing and reports valid 0.
- R12: A next command returns the smallest stored key strictly greater than the loaded key, by loading it into the key registers with valid 1, destination and type. When no such key exists, it returns valid 0 and leaves the key registers unchanged.
- R13: Register writes that arrive while a command is running are ignored. Codes 9..15 change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The table is first filled with twenty keys spread so that no bucket overflows. Reading every key back separates correct hashing and placement from aliasing between ways. A second pattern packs five keys into one bucket, which exercises the free-way choice, the full flag, and replacement of an aged entry. A third pattern mixes all four entry types under repeated aging, which shows whether only NORMAL entries age out. The ordered walk with alternating next codes checks the key comparison across the whole table, including the end-of-table report.

// File: rtl/mactab_pkg.sv
package mactab_pkg;
  localparam int KEY_W  = 60;
  localparam int DEST_W = 7;

  localparam logic [3:0] CMD_IDLE   = 4'd0;
  localparam logic [3:0] CMD_LEARN  = 4'd1;
  localparam logic [3:0] CMD_FORGET = 4'd2;
  localparam logic [3:0] CMD_AGE    = 4'd3;
  localparam logic [3:0] CMD_NEXT   = 4'd4;
  localparam logic [3:0] CMD_CLEAR  = 4'd5;
  localparam logic [3:0] CMD_READ   = 4'd6;
  localparam logic [3:0] CMD_WRITE  = 4'd7;
  localparam logic [3:0] CMD_SNEXT  = 4'd8;

  localparam logic [1:0] ET_NORMAL = 2'd0;

  localparam logic [DEST_W-1:0] DEST_CPU = 7'd58;

  typedef struct packed {
    logic              vld;
    logic              aged;
    logic [1:0]        etype;
    logic [DEST_W-1:0] dest;
    logic [KEY_W-1:0]  key;
  } ent_t;

  // Fold the key into a bucket number: result bit j is the parity of key bits i, i mod bw == j
  function automatic logic [7:0] key_fold(input logic [KEY_W-1:0] k, input int bw);
    logic [7:0] h;
    h = '0;
    for (int i = 0; i < KEY_W; i++) h[i % bw] = h[i % bw] ^ k[i];
    return h;
  endfunction

  function automatic logic is_sweep(input logic [3:0] c);
    return (c == CMD_AGE) || (c == CMD_NEXT) || (c == CMD_CLEAR) || (c == CMD_SNEXT);
  endfunction
endpackage

// File: rtl/mactab_store.sv
module mactab_store
  import mactab_pkg::*;
#(
  parameter int NENT = 32,
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  ent_t                 wdata,
  output ent_t [NENT-1:0]      ents_o
);
  for (genvar g = 0; g < NENT; g++) begin : g_ent
    ent_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            r <= '0;
      else if (we && (widx == IDX_W'(g)))    r <= wdata;
    end
    assign ents_o[g] = r;
  end
endmodule

// File: rtl/mactab_pick.sv
module mactab_pick
  import mactab_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  ent_t [WAYS-1:0]  ways_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             free,
  output logic [WAY_W-1:0] free_way,
  output logic             old,
  output logic [WAY_W-1:0] old_way
);
  logic unused_dest;
  always_comb begin
    unused_dest = 1'b0;
    for (int w = 0; w < WAYS; w++) unused_dest = unused_dest ^ (^ways_i[w].dest);
  end

  // Walk from the top way down so that the lowest qualifying way wins
  always_comb begin
    hit = 1'b0; hit_way = '0;
    free = 1'b0; free_way = '0;
    old = 1'b0; old_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (ways_i[w].vld && (ways_i[w].key == key_i)) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (!ways_i[w].vld) begin
        free = 1'b1; free_way = WAY_W'(w);
      end
      if (ways_i[w].vld && ways_i[w].aged && (ways_i[w].etype == ET_NORMAL)) begin
        old = 1'b1; old_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/mactab_engine.sv
module mactab_engine
  import mactab_pkg::*;
#(
  parameter int BKT_W = 3,
  parameter int WAYS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int NBKT  = 1 << BKT_W;
  localparam int NENT  = NBKT * WAYS;
  localparam int IDX_W = $clog2(NENT);
  localparam int WAY_W = $clog2(WAYS);

  logic [31:0]       key_lo_q;
  logic [27:0]       key_hi_q;
  logic [3:0]        cmd_q;
  logic [1:0]        ety_q;
  logic [DEST_W-1:0] dest_q;
  logic              vld_q, full_q;
  logic [IDX_W-1:0]  scan_q, best_idx_q;
  logic              best_found_q;

  ent_t [NENT-1:0]   ents;
  ent_t [WAYS-1:0]   ways;
  logic [KEY_W-1:0]  key;
  logic [BKT_W-1:0]  bkt;
  logic              hit, free, old;
  logic [WAY_W-1:0]  hit_way, free_way, old_way;
  ent_t              hit_ent, cur, best_ent, nx_ent;

  // Named internal events
  logic              busy, sweep, scan_last, walk, cand_ok, nx_found, learn_fail;
  logic [IDX_W-1:0]  nx_idx;
  logic [NENT-1:0]   vld_map;

  logic              st_we;
  logic [IDX_W-1:0]  st_idx;
  ent_t              st_wd;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[31:28];

  assign key       = {key_hi_q, key_lo_q};
  assign bkt       = key_fold(key, BKT_W)[BKT_W-1:0];
  assign busy      = (cmd_q != CMD_IDLE);
  assign sweep     = is_sweep(cmd_q);
  assign walk      = (cmd_q == CMD_NEXT) || (cmd_q == CMD_SNEXT);
  assign scan_last = (scan_q == IDX_W'(NENT - 1));
  assign cur       = ents[scan_q];
  assign hit_ent   = ways[hit_way];
  assign best_ent  = ents[best_idx_q];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign ways[w] = ents[{bkt, WAY_W'(w)}];
  end
  for (genvar e = 0; e < NENT; e++) begin : g_map
    assign vld_map[e] = ents[e].vld;
  end

  mactab_store #(.NENT(NENT)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .widx(st_idx), .wdata(st_wd), .ents_o(ents)
  );

  mactab_pick #(.WAYS(WAYS)) u_pick (
    .ways_i(ways), .key_i(key),
    .hit(hit), .hit_way(hit_way), .free(free), .free_way(free_way),
    .old(old), .old_way(old_way)
  );

  // Ordered walk: keep the smallest stored key above the loaded one
  assign cand_ok  = cur.vld && (cur.key > key) && (!best_found_q || (cur.key < best_ent.key));
  assign nx_found = best_found_q || cand_ok;
  assign nx_idx   = cand_ok ? scan_q : best_idx_q;
  assign nx_ent   = ents[nx_idx];

  // Single store write port shared by all commands
  always_comb begin
    st_we      = 1'b0;
    st_idx     = scan_q;
    st_wd      = cur;
    learn_fail = 1'b0;
    case (cmd_q)
      CMD_CLEAR: begin
        st_we = 1'b1;
        st_wd = '0;
      end
      CMD_AGE: begin
        if (cur.vld && (cur.etype == ET_NORMAL)) begin
          st_we = 1'b1;
          if (cur.aged) st_wd = '0;
          else          st_wd.aged = 1'b1;
        end
      end
      CMD_LEARN: begin
        if (vld_q) begin
          st_wd       = '0;
          st_wd.vld   = 1'b1;
          st_wd.etype = ety_q;
          st_wd.dest  = dest_q;
          st_wd.key   = key;
          if (hit)       begin st_we = 1'b1; st_idx = {bkt, hit_way};  end
          else if (free) begin st_we = 1'b1; st_idx = {bkt, free_way}; end
          else if (old)  begin st_we = 1'b1; st_idx = {bkt, old_way};  end
          else           learn_fail = 1'b1;
        end else if (hit) begin
          st_we  = 1'b1;
          st_idx = {bkt, hit_way};
          st_wd  = '0;
        end
      end
      CMD_FORGET: begin
        if (hit && (hit_ent.etype == ety_q)) begin
          st_we  = 1'b1;
          st_idx = {bkt, hit_way};
          st_wd  = '0;
        end
      end
      CMD_WRITE: begin
        if (hit) begin
          st_we       = 1'b1;
          st_idx      = {bkt, hit_way};
          st_wd       = hit_ent;
          st_wd.etype = ety_q;
          st_wd.dest  = dest_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_lo_q     <= '0;
      key_hi_q     <= '0;
      cmd_q        <= CMD_IDLE;
      ety_q        <= '0;
      dest_q       <= '0;
      vld_q        <= 1'b0;
      full_q       <= 1'b0;
      scan_q       <= '0;
      best_idx_q   <= '0;
      best_found_q <= 1'b0;
    end else if (!busy) begin
      if (reg_we) begin
        case (reg_addr)
          2'd0: key_lo_q <= reg_wdata;
          2'd1: key_hi_q <= reg_wdata[27:0];
          2'd2: begin
            cmd_q  <= reg_wdata[3:0];
            ety_q  <= reg_wdata[5:4];
            dest_q <= reg_wdata[12:6];
            vld_q  <= reg_wdata[13];
          end
          default: ;
        endcase
      end
    end else if (sweep) begin
      scan_q <= scan_q + 1'b1;
      if (walk) begin
        best_found_q <= nx_found;
        best_idx_q   <= nx_idx;
      end
      if (scan_last) begin
        cmd_q        <= CMD_IDLE;
        scan_q       <= '0;
        best_found_q <= 1'b0;
        if (cmd_q == CMD_CLEAR) full_q <= 1'b0;
        if (walk) begin
          vld_q <= nx_found;
          if (nx_found) begin
            {key_hi_q, key_lo_q} <= nx_ent.key;
            dest_q               <= nx_ent.dest;
            ety_q                <= nx_ent.etype;
          end
        end
      end
    end else begin
      cmd_q <= CMD_IDLE;
      if (learn_fail) full_q <= 1'b1;
      if (cmd_q == CMD_READ) begin
        vld_q  <= hit;
        dest_q <= hit ? hit_ent.dest  : '0;
        ety_q  <= hit ? hit_ent.etype : '0;
      end
      if (cmd_q == CMD_WRITE) vld_q <= hit;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = key_lo_q;
      2'd1:    reg_rdata = {4'b0, key_hi_q};
      2'd2:    reg_rdata = {17'b0, full_q, vld_q, dest_q, ety_q, cmd_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mactab_chk.sv
module mactab_chk #(
  parameter int NENT = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      cmd_q,
  input logic            busy,
  input logic            sweep,
  input logic            scan_last,
  input logic            reg_we,
  input logic [31:0]     key_lo_q,
  input logic            full_q,
  input logic [NENT-1:0] vld_map
);
  // R3
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sweep) |=> (cmd_q == 4'd0));

  // R13
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && cmd_q != 4'd4 && cmd_q != 4'd8) |=> $stable(key_lo_q));

  // R5
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && cmd_q != 4'd5) |=> full_q);

  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 4'd5 && scan_last) |=> (vld_map == '0));

  // R9
  age_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 4'd3) |=> ($countones(vld_map) <= $past($countones(vld_map))));

  // R4
  learn_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 4'd1) |=> ($countones(vld_map) <= $past($countones(vld_map)) + 1));
endmodule

bind mactab_engine mactab_chk #(.NENT(NENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_q(cmd_q), .busy(busy), .sweep(sweep),
  .scan_last(scan_last), .reg_we(reg_we), .key_lo_q(key_lo_q),
  .full_q(full_q), .vld_map(vld_map)
);

// File: tb/test_mactab_engine.sv
module test_mactab_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  mactab_engine i_mactab_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic load(input logic [59:0] k);
    wr(2'd0, k[31:0]);
    wr(2'd1, {4'b0, k[59:32]});
  endtask

  task automatic go(input logic [3:0] c, input logic [1:0] t, input logic [6:0] d,
                    input logic v, output int n, output logic [31:0] acc);
    wr(2'd2, {18'b0, v, d, t, c});
    n = 0;
    rd(2'd2, acc);
    while (acc[3:0] != 4'd0 && n < 1000) begin
      @(negedge clk);
      n++;
      rd(2'd2, acc);
    end
  endtask

  // Read the entry for k; returns the access register contents
  task automatic lookup(input logic [59:0] k, output logic [31:0] acc);
    int n;
    load(k);
    go(4'd6, 2'd0, 7'd0, 1'b0, n, acc);
  endtask

  function automatic logic [59:0] kgen(input int i);
    return {12'(i * 7 + 3), 16'(16'h0a00 + i), 32'(i * 32'h9e3779b1 + 1)};
  endfunction

  // Bucket = XOR of all 3-bit chunks of the key (same as R5 bitwise parity rule)
  function automatic int bkt(input logic [59:0] k);
    logic [2:0] h;
    h = '0;
    for (int j = 0; j < 20; j++) h = h ^ k[j*3 +: 3];
    return int'(h);
  endfunction

  logic [59:0] ks [20];
  logic [1:0]  kt [20];
  logic [6:0]  kd [20];
  logic        alive [20];
  logic [59:0] fk [5];
  int          bc [8];

  initial begin
    logic [31:0] v, v2;
    logic [59:0] prev, exp_k;
    logic        exp_f;
    int n, nk, nf;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 key low", v, 0);
    rd(2'd1, v); chk("R1 key high", v, 0);
    rd(2'd2, v); chk("R1 access", v, 0);
    lookup(kgen(0), v); chk("R1 empty table", v[13], 0);

    // R2 register layout
    wr(2'd1, 32'hF123_0123);
    rd(2'd1, v); chk("R2 high register mask", v, 32'h0123_0123);
    wr(2'd0, 32'h4567_89ab);
    rd(2'd0, v); chk("R2 low register", v, 32'h4567_89ab);

    // R8 clear, sweep latency R3
    go(4'd5, 2'd0, 7'd0, 1'b0, n, v);
    chk("R3 sweep length", n, 32);

    // Fill: at most 3 keys per bucket
    for (int b = 0; b < 8; b++) bc[b] = 0;
    nk = 0;
    for (int i = 0; i < 400 && nk < 20; i++) begin
      if (bc[bkt(kgen(i))] < 3) begin
        ks[nk] = kgen(i);
        bc[bkt(kgen(i))]++;
        nk++;
      end
    end
    for (int j = 0; j < 20; j++) begin
      kt[j] = 2'(j % 4);
      kd[j] = (j == 0) ? 7'd58 : 7'((j * 5 + 1) % 128);
      alive[j] = 1'b1;
      load(ks[j]);
      go(4'd1, kt[j], kd[j], 1'b1, n, v);
      if (j == 0) chk("R3 single latency", n, 1);
    end
    for (int j = 0; j < 20; j++) begin
      lookup(ks[j], v);
      chk("R4 learned valid", v[13], 1);
      chk("R10 read dest", v[12:6], kd[j]);
      chk("R10 read type", v[5:4], kt[j]);
    end
    lookup(kgen(999), v);
    chk("R10 miss valid", v[13], 0);
    chk("R10 miss dest/type", v[12:4], 0);

    // R12 ordered walk, alternating codes 4 and 8
    prev = '0;
    load(prev);
    for (int s = 0; s <= 20; s++) begin
      exp_f = 1'b0; exp_k = '0;
      for (int j = 0; j < 20; j++)
        if (ks[j] > prev && (!exp_f || ks[j] < exp_k)) begin exp_f = 1'b1; exp_k = ks[j]; end
      go((s % 2) ? 4'd8 : 4'd4, 2'd0, 7'd0, 1'b0, n, v);
      chk("R12 next found", v[13], exp_f);
      rd(2'd0, v2);
      chk("R12 next key low", v2, exp_f ? exp_k[31:0] : prev[31:0]);
      rd(2'd1, v2);
      chk("R12 next key high", v2, {4'b0, exp_f ? exp_k[59:32] : prev[59:32]});
      if (exp_f) prev = exp_k;
    end

    // R4 overwrite
    load(ks[0]); go(4'd1, 2'd1, 7'd9, 1'b1, n, v);
    kt[0] = 2'd1; kd[0] = 7'd9;
    lookup(ks[0], v);
    chk("R4 overwrite dest", v[12:6], 9);
    chk("R4 overwrite type", v[5:4], 1);

    // R6 forget requires type match (ks[1] is type 1)
    load(ks[1]); go(4'd2, 2'd0, 7'd0, 1'b0, n, v);
    lookup(ks[1], v); chk("R6 wrong type kept", v[13], 1);
    load(ks[1]); go(4'd2, 2'd1, 7'd0, 1'b0, n, v);
    lookup(ks[1], v); chk("R6 forget removes", v[13], 0);
    alive[1] = 1'b0;

    // R7 learn with valid 0 removes any type (ks[2] is type 2)
    load(ks[2]); go(4'd1, 2'd0, 7'd0, 1'b0, n, v);
    lookup(ks[2], v); chk("R7 removed", v[13], 0);
    alive[2] = 1'b0;

    // R11 write
    load(ks[3]); go(4'd7, 2'd3, 7'd77, 1'b0, n, v);
    chk("R11 write hit", v[13], 1);
    kd[3] = 7'd77;
    lookup(ks[3], v); chk("R11 write dest", v[12:6], 77);
    load(ks[2]); go(4'd7, 2'd0, 7'd5, 1'b1, n, v);
    chk("R11 write miss", v[13], 0);
    lookup(ks[2], v); chk("R11 miss no insert", v[13], 0);

    // R9 aging by type
    go(4'd3, 2'd0, 7'd0, 1'b0, n, v);
    lookup(ks[4], v); chk("R9 first pass keeps normal", v[13], 1);
    go(4'd3, 2'd0, 7'd0, 1'b0, n, v);
    for (int j = 0; j < 20; j++) begin
      lookup(ks[j], v);
      chk("R9 survival by type", v[13], alive[j] && (kt[j] != 2'd0));
      if (alive[j] && kt[j] == 2'd0) alive[j] = 1'b0;
    end

    // R13 unknown code
    load(ks[5]); go(4'd12, 2'd0, 7'd3, 1'b0, n, v);
    chk("R13 unknown code latency", n, 1);
    lookup(ks[5], v); chk("R13 unknown code no change", v[12:6], kd[5]);

    // R13 writes during a sweep ignored; R8 clear
    load(ks[5]);
    wr(2'd2, {18'b0, 1'b0, 7'd0, 2'd0, 4'd5});
    wr(2'd0, 32'hdead_beef);
    rd(2'd2, v); chk("R3 busy shows code", v[3:0], 5);
    go(4'd0, 2'd0, 7'd0, 1'b0, n, v);
    while (v[3:0] != 0) begin @(negedge clk); rd(2'd2, v); end
    rd(2'd0, v); chk("R13 busy write ignored", v, ks[5][31:0]);
    lookup(ks[5], v); chk("R8 clear removes locked", v[13], 0);

    // R5 bucket overflow and replacement
    nf = 0;
    for (int i = 500; i < 5000 && nf < 5; i++)
      if (bkt(kgen(i)) == 0) begin fk[nf] = kgen(i); nf++; end
    for (int j = 0; j < 4; j++) begin
      load(fk[j]); go(4'd1, 2'd0, 7'(j + 1), 1'b1, n, v);
    end
    chk("R5 no full yet", v[14], 0);
    load(fk[4]); go(4'd1, 2'd0, 7'd5, 1'b1, n, v);
    chk("R5 full set", v[14], 1);
    lookup(fk[4], v);
    chk("R5 overflow not stored", v[13], 0);
    chk("R5 full sticky", v[14], 1);
    go(4'd3, 2'd0, 7'd0, 1'b0, n, v);
    load(fk[4]); go(4'd1, 2'd0, 7'd5, 1'b1, n, v);
    lookup(fk[0], v); chk("R5 lowest aged replaced", v[13], 0);
    lookup(fk[4], v); chk("R5 replacement stored", v[13], 1);
    lookup(fk[1], v); chk("R5 other way kept", v[13], 1);
    load(fk[1]); go(4'd1, 2'd0, 7'd2, 1'b1, n, v);
    go(4'd3, 2'd0, 7'd0, 1'b0, n, v);
    lookup(fk[2], v); chk("R9 aged twice removed", v[13], 0);
    lookup(fk[1], v); chk("R4 relearn clears age", v[13], 1);
    lookup(fk[4], v); chk("R9 fresh entry kept", v[13], 1);
    go(4'd5, 2'd0, 7'd0, 1'b0, n, v);
    chk("R8 clear resets full", v[14], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule